// File: doc/BRIEF.md
# Graphics Memory Power-Up Sequencer

This block is the controller-side start-up engine for a two-bank synchronous graphics memory. From reset, or from a one-cycle start pulse, it holds clock enable and the data mask high and drives only no-operation commands for a long stabilisation pause. The pause length is a cycle count set by a parameter, chosen from the clock frequency so that it covers 200 microseconds. After the pause it precharges both banks and issues a programmable number of auto-refresh commands, never fewer than two. It also writes the mode register with a value supplied on an input. When all of that is done it raises a ready flag and leaves the memory pins idle.

Each command lasts one cycle. After a precharge and after each refresh the block waits a parameterised number of no-operation cycles. A configuration input decides whether the refresh burst or the mode register write comes first. The refresh count and the order are captured when the pause ends and must stay stable for the whole run. All pin outputs are registered, so the pins always show the step the sequencer was in one cycle earlier.

Top module: `sgram_init_seq`

## Requirements
- R1: While reset is held, and in the cycle right after a start pulse, the outputs are cke=1, dqm=1, command NOP, addr=0 and ready=0. The command is encoded as {cs_n,ras_n,cas_n,we_n,dsf}: NOP=0_111_0, precharge=0_010_0, auto-refresh=0_001_0, mode write=0_000_0.
- R2: After the clearing edge, which is the last edge with reset high or the edge that samples start, the pins show exactly PAUSE_CYC cycles of NOP. The precharge appears PAUSE_CYC+1 cycles after that edge.
- R3: Exactly one precharge is issued in each run. It lasts one cycle and has addr bit 8 high, which selects all banks.
- R4: The number of auto-refresh commands is ref_num, or 2 when ref_num is below 2. Consecutive refreshes are REF_CYC+1 cycles apart.
- R5: The mode write drives addr = mode_val with bits 7 and 8 forced to 0. All other bits pass through unchanged.
- R6: With mode_first=0, the first refresh comes PRE_CYC+1 cycles after the precharge. The mode write comes REF_CYC+1 cycles after the last refresh, and ready rises one cycle after the mode write.
- R7: With mode_first=1, the mode write comes PRE_CYC+1 cycles after the precharge. The first refresh comes one cycle after the mode write, and ready rises REF_CYC+1 cycles after the last refresh.
- R8: In every cycle of a run that is not one of the commands above, the pins show NOP. Once ready is high it stays high with NOP on the pins until start or reset.
- R9: A start pulse in any state clears ready and restarts the whole run with the R2 timing.
- R10: cke and dqm are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous restart of the whole sequence |
| mode_first | input | 1 | 1: mode write before refreshes; 0: after |
| ref_num | input | NREF_W | Requested refresh count (values below 2 give 2) |
| mode_val | input | ADDR_W | Value for the mode register write |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dsf | output | 1 | Special-function strobe |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Memory initialised |

## Verification
Every pin result follows the step that caused it by exactly one register stage. The bench therefore counts edges from the clearing edge and predicts the cycle of each command. The precharge is due at PAUSE_CYC+1, and the first later command comes PRE_CYC+1 after it. Refreshes are spaced REF_CYC+1 apart, and ready comes either one cycle after the mode write or REF_CYC+1 cycles after the last refresh. The bench samples one time unit after each rising edge and records the cycle index of every non-NOP command. It compares those indices with the predicted ones, so a command that arrives one cycle early or late fails.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_PRE_WT,
    ST_REF,
    ST_REF_WT,
    ST_MRS,
    ST_READY
  } sgi_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic dsf;
  } sgi_cmd_t;

  localparam sgi_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dsf: 1'b0};
  localparam sgi_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, dsf: 1'b0};
  localparam sgi_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, dsf: 1'b0};
  localparam sgi_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, dsf: 1'b0};

endpackage

// File: rtl/sgi_wait_timer.sv
module sgi_wait_timer #(
  parameter int CNT_W = 8,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_W'(INIT);
    else if (ld)           cnt_q <= ld_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R2: an unloaded, unfinished wait shrinks by one each cycle
  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sgi_step_fsm.sv
module sgi_step_fsm
  import sgi_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NREF_W    = 4,
  parameter int PAUSE_CYC = 50000,
  parameter int PRE_CYC   = 4,
  parameter int REF_CYC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tmr_done,
  input  logic              mode_first,
  input  logic [NREF_W-1:0] ref_num,
  output sgi_state_e        st,
  output logic              ld,
  output logic [CNT_W-1:0]  ld_val,
  output logic              order_q
);

  localparam logic [CNT_W-1:0]  PAUSE_LD = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0]  PRE_LD   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0]  REF_LD   = CNT_W'(REF_CYC - 1);
  localparam logic [NREF_W-1:0] MIN_REF  = NREF_W'(2);

  sgi_state_e        st_q, st_d;
  logic [NREF_W-1:0] eff_q, done_q;
  logic [NREF_W-1:0] eff_in;

  assign eff_in = (ref_num < MIN_REF) ? MIN_REF : ref_num;
  assign st     = st_q;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_PAUSE:  if (tmr_done) st_d = ST_PRE;
      ST_PRE: begin
        st_d   = ST_PRE_WT;
        ld     = 1'b1;
        ld_val = PRE_LD;
      end
      ST_PRE_WT: if (tmr_done) st_d = order_q ? ST_MRS : ST_REF;
      ST_REF: begin
        st_d   = ST_REF_WT;
        ld     = 1'b1;
        ld_val = REF_LD;
      end
      ST_REF_WT:
        if (tmr_done) begin
          if (done_q >= eff_q) st_d = order_q ? ST_READY : ST_MRS;
          else                 st_d = ST_REF;
        end
      ST_MRS:    st_d = order_q ? ST_REF : ST_READY;
      ST_READY:  st_d = ST_READY;
      default:   st_d = ST_PAUSE;
    endcase
    if (start) begin
      st_d   = ST_PAUSE;
      ld     = 1'b1;
      ld_val = PAUSE_LD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PAUSE;
      done_q  <= '0;
      eff_q   <= MIN_REF;
      order_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start || st_q == ST_PAUSE) done_q <= '0;
      else if (st_q == ST_REF)       done_q <= done_q + 1'b1;
      if (!start && st_q == ST_PAUSE && tmr_done) begin
        eff_q   <= eff_in;
        order_q <= mode_first;
      end
    end
  end

  // R4: refresh tally stays within the captured target, which is at least two
  assert_ref_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REF_WT) |-> (done_q != '0 && done_q <= eff_q && eff_q >= MIN_REF));

  // R8: ready is a terminal state until start
  assert_ready_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_READY && !start) |=> (st_q == ST_READY));

endmodule

// File: rtl/sgi_pin_reg.sv
module sgi_pin_reg
  import sgi_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  sgi_state_e        st,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke_q,
  output logic              dqm_q,
  output sgi_cmd_t          cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ready_q
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] MRS_MASK  = ~(ADDR_W'(3) << 7);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cke_q   <= 1'b1;
      dqm_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      cke_q   <= 1'b1;
      dqm_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
      case (st)
        ST_PRE: begin
          cmd_q  <= CMD_PRE;
          addr_q <= ALL_BANKS;
        end
        ST_REF:   cmd_q <= CMD_REF;
        ST_MRS: begin
          cmd_q  <= CMD_MRS;
          addr_q <= mode_val & MRS_MASK;
        end
        ST_READY: ready_q <= 1'b1;
        default:  ;
      endcase
    end
  end

  // R3: precharge always carries the all-banks bit
  assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> addr_q[8]);

  // R5: reserved mode bits are zero during the mode write
  assert_mrs_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (addr_q[8:7] == 2'b00));

  // R8: pins are idle while ready
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (cmd_q == CMD_NOP));

  // R10: clock enable and mask never drop
  assert_cke_dqm_R10: assert property (@(posedge clk) disable iff (rst)
    (cke_q && dqm_q));

endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgi_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NREF_W    = 4,
  parameter int PAUSE_CYC = 50000,
  parameter int PRE_CYC   = 4,
  parameter int REF_CYC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_first,
  input  logic [NREF_W-1:0] ref_num,
  input  logic [ADDR_W-1:0] mode_val,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dsf,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int MAX_A    = (PAUSE_CYC > PRE_CYC) ? PAUSE_CYC : PRE_CYC;
  localparam int MAX_WAIT = (MAX_A > REF_CYC) ? MAX_A : REF_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  sgi_state_e       st;
  logic             ld, tmr_done, order_q;
  logic [CNT_W-1:0] ld_val;
  sgi_cmd_t         cmd;

  sgi_wait_timer #(.CNT_W(CNT_W), .INIT(PAUSE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val), .done(tmr_done)
  );

  sgi_step_fsm #(
    .CNT_W(CNT_W), .NREF_W(NREF_W), .PAUSE_CYC(PAUSE_CYC),
    .PRE_CYC(PRE_CYC), .REF_CYC(REF_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .tmr_done(tmr_done),
    .mode_first(mode_first), .ref_num(ref_num), .st(st),
    .ld(ld), .ld_val(ld_val), .order_q(order_q)
  );

  sgi_pin_reg #(.ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst(rst), .clr(start), .st(st), .mode_val(mode_val),
    .cke_q(cke), .dqm_q(dqm), .cmd_q(cmd), .addr_q(addr), .ready_q(ready)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign dsf   = cmd.dsf;

  // R2: the pause step shows only NOP on the pins
  assert_pause_nop_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE && !start) |=> (cmd == CMD_NOP));

  // R6: in the normal order ready rises right after the mode write
  assert_ready_after_mrs_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && !order_q) |-> ($past(cmd) == CMD_MRS));

  // R9: start always drops ready on the next cycle
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready);

endmodule

// File: tb/sgram_init_seq_test.sv
module sgram_init_seq_test;

  localparam int P = 12;
  localparam int T = 3;
  localparam int F = 5;

  typedef struct packed {
    logic       mf;
    logic [3:0] nref;
    logic [9:0] mval;
    logic [3:0] exp_n;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b0, 4'd2, 10'h3FF, 4'd2},
    '{1'b0, 4'd0, 10'h123, 4'd2},
    '{1'b1, 4'd1, 10'h0A5, 4'd2},
    '{1'b1, 4'd5, 10'h2B6, 4'd5},
    '{1'b0, 4'd7, 10'h180, 4'd7},
    '{1'b1, 4'd3, 10'h031, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_first = 1'b0;
  logic [3:0] ref_num = 4'd2;
  logic [9:0] mode_val = '0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, dsf, ready;
  logic [9:0] addr;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sgram_init_seq #(.ADDR_W(10), .NREF_W(4), .PAUSE_CYC(P), .PRE_CYC(T), .REF_CYC(F)) uut (
    .clk(clk), .rst(rst), .start(start), .mode_first(mode_first),
    .ref_num(ref_num), .mode_val(mode_val), .cke(cke), .dqm(dqm),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dsf(dsf),
    .addr(addr), .ready(ready)
  );

  function automatic logic [4:0] pins();
    return {cs_n, ras_n, cas_n, we_n, dsf};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle_check(input string req);
    chk(cke === 1'b1 && dqm === 1'b1, req, {cke, dqm}, 3);
    chk(pins() === 5'b01110, req, pins(), 5'b01110);
    chk(ready === 1'b0 && addr === 10'd0, req, {ready, addr}, 0);
  endtask

  task automatic run_seq(input vec_t v, input string tag);
    int k, npre, nref, nmrs, pre_t, mrs_t, rdy_t, extra, other, pinbad, late;
    int ref_t [0:15];
    logic [9:0] mrs_a;
    logic pre_a8;
    int tp, first, exp_mrs, exp_rdy;
    npre = 0; nref = 0; nmrs = 0; pre_t = -1; mrs_t = -1; rdy_t = -1;
    extra = 0; other = 0; pinbad = 0; late = 0; mrs_a = '0; pre_a8 = 1'b0;
    @(negedge clk);
    mode_first = v.mf;
    ref_num = v.nref;
    mode_val = v.mval;
    start = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    start = 1'b0;
    // R9 and R1: cycle after start is cleared
    idle_check({tag, " R9 cleared after start"});
    k = 0;
    while (k < 400 && extra < 4) begin
      @(posedge clk); #1;
      k++;
      if (!(cke === 1'b1 && dqm === 1'b1)) pinbad++;
      case (pins())
        5'b01110: ;
        5'b00100: begin npre++; pre_t = k; pre_a8 = addr[8]; end
        5'b00010: begin if (nref < 16) ref_t[nref] = k; nref++; end
        5'b00000: begin nmrs++; mrs_t = k; mrs_a = addr; end
        default:  other++;
      endcase
      if (ready === 1'b1) begin
        if (rdy_t < 0) rdy_t = k;
        if (pins() !== 5'b01110) late++;
        extra++;
      end else if (rdy_t >= 0) late++;
    end
    tp = P + 1;
    // R2: exact pause length, R3: single precharge of all banks
    chk(pre_t == tp, {tag, " R2 precharge cycle"}, pre_t, tp);
    chk(npre == 1 && pre_a8 === 1'b1, {tag, " R3 precharge count/all-banks"}, npre, 1);
    // R4: refresh count
    chk(nref == int'(v.exp_n), {tag, " R4 refresh count"}, nref, v.exp_n);
    chk(nmrs == 1, {tag, " R5 mode write count"}, nmrs, 1);
    chk(mrs_a === (v.mval & 10'h27F), {tag, " R5 mode write address"}, mrs_a, v.mval & 10'h27F);
    if (!v.mf) begin
      first = tp + T + 1;
      exp_mrs = first + int'(v.exp_n) * (F + 1);
      exp_rdy = exp_mrs + 1;
      chk(mrs_t == exp_mrs, {tag, " R6 mode write cycle"}, mrs_t, exp_mrs);
      chk(rdy_t == exp_rdy, {tag, " R6 ready cycle"}, rdy_t, exp_rdy);
    end else begin
      exp_mrs = tp + T + 1;
      first = exp_mrs + 1;
      exp_rdy = first + int'(v.exp_n) * (F + 1);
      chk(mrs_t == exp_mrs, {tag, " R7 mode write cycle"}, mrs_t, exp_mrs);
      chk(rdy_t == exp_rdy, {tag, " R7 ready cycle"}, rdy_t, exp_rdy);
    end
    for (int i = 0; i < int'(v.exp_n) && i < nref && i < 16; i++)
      chk(ref_t[i] == first + i * (F + 1), {tag, " R4 refresh spacing"}, ref_t[i], first + i * (F + 1));
    chk(other == 0, {tag, " R8 no stray command"}, other, 0);
    chk(late == 0 && extra == 4, {tag, " R8 ready held with NOP"}, late, 0);
    chk(pinbad == 0, {tag, " R10 cke/dqm high"}, pinbad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs while reset is held
    idle_check("R1 during reset");
    @(negedge clk);
    rst = 1'b0;

    for (int n = 0; n < 6; n++) run_seq(VEC[n], $sformatf("vec%0d", n));

    // R9: restart from the middle of the refresh burst
    @(negedge clk);
    mode_first = 1'b0;
    ref_num = 4'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (P + T + 8) @(negedge clk);
    run_seq('{1'b0, 4'd3, 10'h1C3, 4'd3}, "restart R9");

    // R1: reset in the middle of a run
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (P + 3) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    idle_check("R1 mid-run reset");
    @(negedge clk);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule